// File: doc/BRIEF.md
# Serial Keyboard Command Responder

This block plays the keyboard end of a serial keyboard link. The host sends command bytes. The block answers a few of them by loading fixed reply strings into a small circular byte queue. It ignores every other byte. Key events arrive ready-translated, as a 7-bit code plus a down/up flag. The block turns each event into one scancode byte and appends it to the same queue.

Caps-lock and num-lock events pass through a filter. The filter makes a physical toggle key look like a latching key: two physical presses give one logical press and one logical release. The receive side pops the queue one byte at a time through a read strobe. The head byte is always visible on the read data port, and a flag shows that the queue holds data.

Top module: `kbd_responder`

## Requirements
- R1: After reset the queue is empty, `notEmpty` is 0 and `rdData` is 0x00.
- R2: Command 0x01 empties the queue and then loads the bytes 0xFF, 0x04, 0x7F, read back in that order.
- R3: Commands 0x07 and 0x0F each empty the queue and then load 0xFE, 0x21, read back in that order.
- R4: Command 0x0E loads nothing. The command byte that follows it is consumed as an argument and has no effect, whatever its value. Bytes after that are decoded normally again.
- R5: Any other command byte leaves the queue contents and the head byte unchanged.
- R6: A press of a non-lock key enqueues `{1'b0, keyCode}`. A release enqueues `{1'b1, keyCode}`.
- R7: Caps-lock and num-lock each keep a 2-bit state that starts at 0. A press flips bit 0 and a release flips bit 1. A press that leaves the state at 2 is dropped, and a release that leaves it at 3 is dropped. The two keys keep separate states, and caps wins when both flags are set.
- R8: The queue holds 16 bytes. A byte offered while the queue is full is discarded, and the stored bytes are kept.
- R9: `rdData` shows the head byte whenever `notEmpty` is 1. A read strobe removes that byte and exposes the next one. With the queue empty, `rdData` is 0x00 and a read changes nothing.
- R10: Within one cycle, the read pops first. A clearing command then empties the queue and writes its reply. The key byte is appended last. Each byte is dropped if no room is left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command byte strobe |
| cmdByte | input | 8 | Command byte from the host |
| keyValid | input | 1 | Key event strobe |
| keyCode | input | 7 | Translated key code |
| keyDown | input | 1 | 1 = press, 0 = release |
| keyIsCaps | input | 1 | Event is the caps-lock key |
| keyIsNum | input | 1 | Event is the num-lock key |
| rdEn | input | 1 | Pop the head byte |
| rdData | output | 8 | Head byte, or 0x00 when empty |
| notEmpty | output | 1 | Queue holds at least one byte |

## Verification
A command reply and a key scancode can land in the queue in the same cycle, and a pop can land with them. The bench drives a layout query, a key press and a read strobe on one clock edge, with the queue partly filled. It then drains the queue and expects the reply bytes followed by the key byte, with the old content gone.

It also offers a key byte together with a pop while the queue is full. This case is judged by the depth staying at 16 and by the new byte appearing last.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  localparam int MAX_PUSH = 4;

  localparam logic [7:0] CMD_IDENT   = 8'h01;
  localparam logic [7:0] CMD_LEDS    = 8'h0E;
  localparam logic [7:0] CMD_LAYOUT0 = 8'h07;
  localparam logic [7:0] CMD_LAYOUT1 = 8'h0F;

  typedef struct packed {
    logic                          clearQ;
    logic                          popQ;
    logic [2:0]                    pushCnt;
    logic [MAX_PUSH-1:0][7:0]      pushByte;
  } kbdStrobe_t;
endpackage

// File: rtl/kbd_lock.sv
module kbd_lock (
  input  logic clk,
  input  logic rstN,
  input  logic hit,
  input  logic down,
  output logic pass
);
  logic [1:0] state, nextState;

  always_comb begin
    nextState = down ? (state ^ 2'b01) : (state ^ 2'b10);
    if (!hit)
      pass = 1'b1;
    else if (down)
      pass = (nextState != 2'd2);
    else
      pass = (nextState != 2'd3);
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      state <= 2'd0;
    else if (hit)
      state <= nextState;
  end
endmodule

// File: rtl/kbd_ctl.sv
module kbd_ctl
  import kbd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [7:0] cmdByte,
  input  logic       keyValid,
  input  logic [6:0] keyCode,
  input  logic       keyDown,
  input  logic       keyIsCaps,
  input  logic       keyIsNum,
  input  logic       rdEn,
  output kbdStrobe_t strb,
  output logic       ledArg
);
  localparam int NLOCK = 2;

  logic [NLOCK-1:0] lockHit, lockPass;
  logic             ledNext, keyPass;
  logic [2:0]       replyCnt;

  assign lockHit[0] = keyValid & keyIsCaps;
  assign lockHit[1] = keyValid & keyIsNum & ~keyIsCaps;

  for (genvar g = 0; g < NLOCK; g++) begin : gLock
    kbd_lock uLock (
      .clk (clk),
      .rstN(rstN),
      .hit (lockHit[g]),
      .down(keyDown),
      .pass(lockPass[g])
    );
  end

  assign keyPass = keyValid & (&lockPass);

  always_comb begin
    strb     = '0;
    replyCnt = 3'd0;
    ledNext  = ledArg;
    strb.popQ = rdEn;
    if (cmdValid) begin
      if (ledArg) begin
        ledNext = 1'b0;
      end else begin
        case (cmdByte)
          CMD_IDENT: begin
            strb.clearQ      = 1'b1;
            strb.pushByte[0] = 8'hFF;
            strb.pushByte[1] = 8'h04;
            strb.pushByte[2] = 8'h7F;
            replyCnt         = 3'd3;
          end
          CMD_LEDS: ledNext = 1'b1;
          CMD_LAYOUT0, CMD_LAYOUT1: begin
            strb.clearQ      = 1'b1;
            strb.pushByte[0] = 8'hFE;
            strb.pushByte[1] = 8'h21;
            replyCnt         = 3'd2;
          end
          default: ;
        endcase
      end
    end
    strb.pushCnt = replyCnt;
    if (keyPass) begin
      strb.pushByte[replyCnt[1:0]] = {~keyDown, keyCode};
      strb.pushCnt = replyCnt + 3'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      ledArg <= 1'b0;
    else
      ledArg <= ledNext;
  end
endmodule

// File: rtl/kbd_queue.sv
module kbd_queue
  import kbd_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  kbdStrobe_t                   strb,
  output logic [7:0]                   rdData,
  output logic                         notEmpty,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] rdPtr, wrPtr, rdAfter, wrBase;
  logic [CW-1:0] cntAfter, room, accepted, reqCnt;
  logic          doPop;

  assign notEmpty = (count != '0);
  assign rdData   = notEmpty ? mem[rdPtr] : 8'h00;
  assign doPop    = strb.popQ & notEmpty;

  always_comb begin
    if (strb.clearQ) begin
      cntAfter = '0;
      rdAfter  = '0;
      wrBase   = '0;
    end else begin
      cntAfter = count - CW'(doPop);
      rdAfter  = rdPtr + PW'(doPop);
      wrBase   = wrPtr;
    end
    room     = CW'(DEPTH) - cntAfter;
    reqCnt   = CW'(strb.pushCnt);
    accepted = (reqCnt < room) ? reqCnt : room;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else begin
      rdPtr <= rdAfter;
      wrPtr <= wrBase + PW'(accepted);
      count <= cntAfter + accepted;
      for (int i = 0; i < MAX_PUSH; i++) begin
        if (CW'(i) < accepted)
          mem[wrBase + PW'(i)] <= strb.pushByte[i];
      end
    end
  end
endmodule

// File: rtl/kbd_responder.sv
module kbd_responder
  import kbd_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [7:0] cmdByte,
  input  logic       keyValid,
  input  logic [6:0] keyCode,
  input  logic       keyDown,
  input  logic       keyIsCaps,
  input  logic       keyIsNum,
  input  logic       rdEn,
  output logic [7:0] rdData,
  output logic       notEmpty
);
  localparam int CW = $clog2(DEPTH+1);

  kbdStrobe_t    strb;
  logic          ledArg;
  logic [CW-1:0] qCount;

  kbd_ctl uCtl (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdByte(cmdByte),
    .keyValid(keyValid), .keyCode(keyCode), .keyDown(keyDown),
    .keyIsCaps(keyIsCaps), .keyIsNum(keyIsNum),
    .rdEn(rdEn), .strb(strb), .ledArg(ledArg)
  );

  kbd_queue #(.DEPTH(DEPTH)) uQueue (
    .clk(clk), .rstN(rstN), .strb(strb),
    .rdData(rdData), .notEmpty(notEmpty), .count(qCount)
  );
endmodule

// File: rtl/kbd_checker.sv
module kbd_checker #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH+1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          cmdValid,
  input logic [7:0]    cmdByte,
  input logic          keyValid,
  input logic          rdEn,
  input logic [7:0]    rdData,
  input logic          notEmpty,
  input logic [CW-1:0] qCount,
  input logic          ledArg
);
  logic plainCmd;
  assign plainCmd = cmdValid && !ledArg &&
                    !(cmdByte inside {8'h01, 8'h07, 8'h0E, 8'h0F});

  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    qCount <= CW'(DEPTH));

  // R9
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !notEmpty |-> rdData == 8'h00);

  // R2
  ident_reply_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !ledArg && cmdByte == 8'h01 && !keyValid
    |=> qCount == CW'(3) && rdData == 8'hFF);

  // R3
  layout_reply_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !ledArg && (cmdByte == 8'h07 || cmdByte == 8'h0F) && !keyValid
    |=> qCount == CW'(2) && rdData == 8'hFE);

  // R4
  led_arg_consume_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && ledArg |=> !ledArg);

  // R4
  led_arg_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !ledArg && cmdByte == 8'h0E |=> ledArg);

  // R5
  plain_cmd_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    plainCmd && !keyValid && !rdEn |=> $stable(qCount) && $stable(rdData));
endmodule

bind kbd_responder kbd_checker #(.DEPTH(DEPTH)) uChk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdByte(cmdByte),
  .keyValid(keyValid), .rdEn(rdEn), .rdData(rdData), .notEmpty(notEmpty),
  .qCount(qCount), .ledArg(ledArg)
);

// File: tb/tb_kbd_responder.sv
module tb_kbd_responder;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [7:0] cmdByte = 8'h00;
  logic       keyValid = 1'b0;
  logic [6:0] keyCode = 7'h00;
  logic       keyDown = 1'b0;
  logic       keyIsCaps = 1'b0;
  logic       keyIsNum = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] rdData;
  logic       notEmpty;

  int nChecks = 0;
  int nErr = 0;

  logic [7:0] mq[$];
  bit         ledPend = 0;
  int         capsS = 0;
  int         numS = 0;

  always #10 clk = ~clk;

  kbd_responder dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdByte(cmdByte),
    .keyValid(keyValid), .keyCode(keyCode), .keyDown(keyDown),
    .keyIsCaps(keyIsCaps), .keyIsNum(keyIsNum), .rdEn(rdEn),
    .rdData(rdData), .notEmpty(notEmpty)
  );

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] headExp();
    return (mq.size() > 0) ? mq[0] : 8'h00;
  endfunction

  function automatic void mPush(input logic [7:0] b);
    if (mq.size() < 16) mq.push_back(b);
  endfunction

  task automatic step(input logic cv, input logic [7:0] cb, input logic kv,
                      input logic [6:0] kc, input logic kd, input logic kcaps,
                      input logic knum, input logic rd, input string tag);
    bit pass;
    @(negedge clk);
    cmdValid = cv; cmdByte = cb; keyValid = kv; keyCode = kc;
    keyDown = kd; keyIsCaps = kcaps; keyIsNum = knum; rdEn = rd;
    if (rd) chk(rdData == headExp(), tag, rdData, headExp());
    if (rd && mq.size() > 0) void'(mq.pop_front());
    if (cv) begin
      if (ledPend) ledPend = 0;
      else case (cb)
        8'h01: begin mq.delete(); mPush(8'hFF); mPush(8'h04); mPush(8'h7F); end
        8'h0E: ledPend = 1;
        8'h07, 8'h0F: begin mq.delete(); mPush(8'hFE); mPush(8'h21); end
        default: ;
      endcase
    end
    if (kv) begin
      pass = 1;
      if (kcaps) begin
        capsS ^= kd ? 1 : 2;
        pass = kd ? (capsS != 2) : (capsS != 3);
      end else if (knum) begin
        numS ^= kd ? 1 : 2;
        pass = kd ? (numS != 2) : (numS != 3);
      end
      if (pass) mPush({~kd, kc});
    end
    @(negedge clk);
    cmdValid = 0; keyValid = 0; rdEn = 0; keyIsCaps = 0; keyIsNum = 0;
    chk(notEmpty == (mq.size() > 0), tag, {7'd0, notEmpty}, {7'd0, mq.size() > 0});
    chk(rdData == headExp(), tag, rdData, headExp());
  endtask

  task automatic cmd(input logic [7:0] b, input string tag);
    step(1, b, 0, 7'h0, 0, 0, 0, 0, tag);
  endtask

  task automatic key(input logic [6:0] c, input logic d, input logic cp, input logic nm, input string tag);
    step(0, 8'h0, 1, c, d, cp, nm, 0, tag);
  endtask

  task automatic drain(input string tag);
    int guard = 0;
    while ((mq.size() > 0 || notEmpty) && guard < 20) begin
      step(0, 8'h0, 0, 7'h0, 0, 0, 0, 1, tag);
      guard++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nErr++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk(notEmpty == 1'b0, "R1", {7'd0, notEmpty}, 8'h00);
    chk(rdData == 8'h00, "R1", rdData, 8'h00);
    // R9 empty read
    step(0, 8'h0, 0, 7'h0, 0, 0, 0, 1, "R9");

    // R2 R3 R5 sweep of every command byte
    for (int b = 0; b < 256; b++) begin
      if (b == 1) cmd(8'(b), "R2");
      else if (b == 7 || b == 15) cmd(8'(b), "R3");
      else if (b == 14) cmd(8'(b), "R4");
      else cmd(8'(b), "R5");
      drain("R9");
    end
    cmd(8'h20, "R4");

    // R4 argument byte is swallowed even when it is a real command
    cmd(8'h0E, "R4");
    cmd(8'h01, "R4");
    chk(notEmpty == 1'b0, "R4", {7'd0, notEmpty}, 8'h00);
    cmd(8'h01, "R2");
    drain("R2");

    // R5 unknown command leaves existing content
    key(7'h11, 1, 0, 0, "R6");
    cmd(8'h55, "R5");
    drain("R5");

    // R6 every code, press then release
    for (int c = 0; c < 128; c++) begin
      key(7'(c), 1, 0, 0, "R6");
      key(7'(c), 0, 0, 0, "R6");
      drain("R6");
    end

    // R7 lock filters, interleaved caps and num
    for (int n = 0; n < 4; n++) begin
      key(7'h77, 1, 1, 0, "R7");
      key(7'h62, 1, 0, 1, "R7");
      key(7'h77, 0, 1, 0, "R7");
      key(7'h62, 0, 0, 1, "R7");
    end
    key(7'h77, 1, 1, 1, "R7");
    key(7'h77, 0, 1, 1, "R7");
    drain("R7");

    // R8 overflow
    for (int c = 0; c < 20; c++) key(7'(c + 32), 1, 0, 0, "R8");
    drain("R8");

    // R10 pop, clear, reply and key in one cycle
    key(7'h01, 1, 0, 0, "R10");
    key(7'h02, 1, 0, 0, "R10");
    key(7'h03, 1, 0, 0, "R10");
    step(1, 8'h07, 1, 7'h05, 1, 0, 0, 1, "R10");
    drain("R10");
    step(1, 8'h01, 1, 7'h09, 0, 0, 0, 0, "R10");
    drain("R10");
    // R10 full queue, pop and key together
    for (int c = 0; c < 16; c++) key(7'(c), 1, 0, 0, "R10");
    step(0, 8'h0, 1, 7'h7E, 1, 0, 0, 1, "R10");
    drain("R10");

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule